// File: doc/BRIEF.md
# MAC Accumulator Rounding and Saturation Unit

This unit is the support logic around a multiply-accumulate engine. It holds four accumulators and a mode register. The accumulators are kept 64 bits wide so that a sum wider than 48 bits can still be saturated. The unit forms products of two 32-bit operands, with overflow detection that depends on the mode. It can saturate an accumulator in place, set condition flags from one accumulator, and give a 32-bit or 16-bit readout of an accumulator with rounding and clamping. The accumulate adder itself and the instruction decode sit outside this block. An external adder writes its sums back through the load command.

Each operation is a single-cycle command. The command is presented on `cmdOp` with `cmdValid` high, and `accSel` (plus `accSrc` for a move) picks the accumulators. Status flags and a per-accumulator overflow bit collect events. They stay set until software writes the mode register again, so a sequence of operations can be checked once at its end.

The mode register has four bits: bit 0 `satEn` (saturate on overflow), bit 1 `sel16` (signed integer mode, or 16-bit readout when fractional), bit 2 `fracEn` (fractional mode) and bit 3 `rndEn` (rounding). The status output is {ev, v, n, z} from bit 3 down to bit 0.

Top module: `macAccUnit`

## Requirements
- R1: Command multiply (`cmdOp` 1) in signed mode (`fracEn`=0, `sel16`=1) multiplies the operands as signed values. A product outside the signed 40-bit range sets status v. In that case the product becomes 2^50 (positive) or ~2^50 (negative) when `satEn`=1, and the low 40 bits sign-extended when `satEn`=0. The result appears on `prodOut` one cycle after the command.
- R2: Multiply in unsigned mode (`fracEn`=0, `sel16`=0) multiplies the operands as unsigned values. A product of 2^40 or more sets v and becomes 2^50 when `satEn`=1, or its low 40 bits when `satEn`=0.
- R3: Multiply in fractional mode (`fracEn`=1) gives the signed product arithmetically shifted right by 24. With `rndEn`=1, a 24-bit remainder above 0x800000 rounds up and a remainder of exactly 0x800000 rounds to the even result. This mode never sets v.
- R4: Saturate (`cmdOp` 4) in signed or fractional mode treats an accumulator outside the signed 48-bit range as an overflow. An overflow sets v and the accumulator's sticky overflow bit. With `satEn`=1 the value becomes 0x7FFFFFFF or its complement (signed mode), or 2^47-1 or its complement (fractional mode), with the sign taken from bit 63. Otherwise the accumulator is sign-extended from bit 47.
- R5: Saturate in unsigned mode treats any set bit among bits 63..48 as an overflow, which sets v and the sticky bit. With `satEn`=1 the value becomes 0 if it is above 2^53 and 2^48-1 otherwise. Without `satEn` it is masked to 48 bits.
- R6: Set-flags (`cmdOp` 6) ORs the following into the status register. z is set if the accumulator is zero; otherwise n is set from bit 47. v is set if the accumulator's sticky overflow bit is set. ev is set if the value is outside the signed 41-bit range (fractional mode), outside the signed 33-bit range (signed mode), or 2^32 or more (unsigned mode).
- R7: Read (`cmdOp` 5) in fractional mode updates `rdData` one cycle later. With `sel16`=1 the value is shifted right arithmetically by 24 and always rounded half-to-even on the 24-bit remainder; the low 16 bits are returned zero-extended, clamped to 0x7FFF or 0x8000 when `satEn`=1 and the value is outside the signed 16-bit range. With `sel16`=0 the value is shifted right by 8, rounded half-to-even on the 8-bit remainder only when `rndEn`=1, and clamped to 0x7FFFFFFF or 0x80000000 when `satEn`=1.
- R8: Read in signed integer mode returns the low 32 bits, or 0x7FFFFFFF or 0x80000000 when the value does not fit in signed 32 bits. In unsigned mode it returns the low 32 bits, or 0xFFFFFFFF when any bit above bit 31 is set.
- R9: Load (`cmdOp` 2) writes `loadData` into the selected accumulator. Move (`cmdOp` 3) copies accumulator `accSrc` into `accSel`, together with its sticky overflow bit. `accOut` always shows the accumulator selected by `accSel`.
- R10: Reset clears every accumulator, the mode, the status and the sticky bits. Write-mode (`cmdOp` 7) loads `modeIn` and clears the status and all sticky bits. Apart from that, status bits never clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| accSel | input | 2 | Target accumulator |
| accSrc | input | 2 | Source accumulator for a move |
| opA | input | 32 | First multiply operand |
| opB | input | 32 | Second multiply operand |
| loadData | input | 64 | Value for a load |
| modeIn | input | 4 | Value for a mode write |
| prodOut | output | 64 | Last product |
| rdData | output | 32 | Last readout |
| accOut | output | 64 | Contents of accumulator `accSel` |
| statusOut | output | 4 | Sticky flags {ev, v, n, z} |
| pavOut | output | 4 | Sticky per-accumulator overflow bits |
| modeOut | output | 4 | Current mode |

## Verification
Every command result lands one clock edge after the command is sampled. This applies to the product, the readout, the new accumulator value, the status and the sticky bits. `accOut` follows `accSel` without delay. The bench drives each command on a falling edge and drops `cmdValid` on the next falling edge, which comes after exactly one rising edge. It compares all outputs at that point against a reference model, which it updates with the same command. An idle cycle separates commands, so no result depends on two edges.

// File: rtl/macPkg.sv
package macPkg;
  localparam int OP_W     = 32;
  localparam int WIDE_W   = 2 * OP_W;
  localparam int ACC_W    = 48;
  localparam int PROD_W   = 40;
  localparam int FRAC_SH  = 24;
  localparam int HALF_SH  = 8;
  localparam int SAT_MARK = 50;
  localparam int HALF_W   = OP_W / 2;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MUL   = 3'd1,
    CMD_LOAD  = 3'd2,
    CMD_MOVE  = 3'd3,
    CMD_SAT   = 3'd4,
    CMD_READ  = 3'd5,
    CMD_FLAGS = 3'd6,
    CMD_MODE  = 3'd7
  } cmd_e;

  typedef struct packed {
    logic rndEn;
    logic fracEn;
    logic sel16;
    logic satEn;
  } mode_t;

  typedef struct packed {
    logic mul;
    logic load;
    logic move;
    logic sat;
    logic read;
    logic flags;
    logic mode;
  } strobe_t;

  typedef struct packed {
    logic ev;
    logic v;
    logic n;
    logic z;
  } status_t;
endpackage

// File: rtl/macCtrl.sv
module macCtrl import macPkg::*; #(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [IDX_W-1:0]   accSel,
  input  logic [IDX_W-1:0]   accSrc,
  input  logic [3:0]         modeIn,
  input  status_t            flagEvt,
  input  logic               ovfEvt,
  output strobe_t            strb,
  output mode_t              mode,
  output status_t            status,
  output logic [NUM_ACC-1:0] pav
);
  status_t pavFlag;

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (cmd_e'(cmdOp))
        CMD_MUL:   strb.mul   = 1'b1;
        CMD_LOAD:  strb.load  = 1'b1;
        CMD_MOVE:  strb.move  = 1'b1;
        CMD_SAT:   strb.sat   = 1'b1;
        CMD_READ:  strb.read  = 1'b1;
        CMD_FLAGS: strb.flags = 1'b1;
        CMD_MODE:  strb.mode  = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    pavFlag   = '0;
    pavFlag.v = strb.flags && pav[accSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      status <= '0;
      pav    <= '0;
    end else if (strb.mode) begin
      mode   <= mode_t'(modeIn);
      status <= '0;
      pav    <= '0;
    end else begin
      status <= status | flagEvt | pavFlag;
      if (ovfEvt)    pav[accSel] <= 1'b1;
      if (strb.move) pav[accSel] <= pav[accSrc];
    end
  end
endmodule

// File: rtl/macDatapath.sv
module macDatapath import macPkg::*; #(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  mode_t             mode,
  input  logic [IDX_W-1:0]  accSel,
  input  logic [IDX_W-1:0]  accSrc,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [WIDE_W-1:0] loadData,
  output logic [WIDE_W-1:0] prodOut,
  output logic [OP_W-1:0]   rdData,
  output logic [WIDE_W-1:0] accOut,
  output status_t           flagEvt,
  output logic              ovfEvt
);
  localparam int W = WIDE_W;
  localparam logic [W-1:0] ONE    = W'(1);
  localparam logic [W-1:0] MARK   = ONE << SAT_MARK;
  localparam logic [W-1:0] POS32  = (ONE << (OP_W - 1)) - ONE;
  localparam logic [W-1:0] POS48  = (ONE << (ACC_W - 1)) - ONE;
  localparam logic [W-1:0] MAX48U = (ONE << ACC_W) - ONE;
  localparam logic [W-1:0] LIM53  = ONE << (ACC_W + 5);
  localparam logic [OP_W-1:0] POS16R = OP_W'((1 << (HALF_W - 1)) - 1);
  localparam logic [OP_W-1:0] NEG16R = OP_W'(1 << (HALF_W - 1));

  logic [W-1:0] accReg [NUM_ACC];
  logic [W-1:0] selVal;

  // arithmetic shift right with optional round-half-to-even on the dropped bits
  function automatic logic [W-1:0] shiftRound(input logic [W-1:0] v, input int sh, input logic en);
    logic signed [W-1:0] q;
    logic [W-1:0] rem;
    logic [W-1:0] half;
    q    = $signed(v) >>> sh;
    rem  = v & ((ONE << sh) - ONE);
    half = ONE << (sh - 1);
    if (en && ((rem > half) || ((rem == half) && q[0]))) q = q + 1;
    return q;
  endfunction

  // true when bits W-1..lo all carry the same value
  function automatic logic sameBits(input logic [W-1:0] v, input int lo);
    logic [W-1:0] s;
    s = $signed(v) >>> lo;
    return (s == '0) || (s == '1);
  endfunction

  assign selVal = accReg[accSel];
  assign accOut = selVal;

  // product path
  logic signed [W-1:0] sProd;
  logic [W-1:0] uProd, sRes, uRes, fRes, mulRes;
  logic sOvf, uOvf, mulOvf;

  always_comb begin
    sProd = $signed({{OP_W{opA[OP_W-1]}}, opA}) * $signed({{OP_W{opB[OP_W-1]}}, opB});
    uProd = {{OP_W{1'b0}}, opA} * {{OP_W{1'b0}}, opB};
    sOvf  = !sameBits(sProd, PROD_W - 1);
    uOvf  = |uProd[W-1:PROD_W];
    if (!sOvf)           sRes = sProd;
    else if (mode.satEn) sRes = sProd[W-1] ? ~MARK : MARK;
    else                 sRes = {{(W-PROD_W){sProd[PROD_W-1]}}, sProd[PROD_W-1:0]};
    if (!uOvf)           uRes = uProd;
    else if (mode.satEn) uRes = MARK;
    else                 uRes = {{(W-PROD_W){1'b0}}, uProd[PROD_W-1:0]};
    fRes   = shiftRound(sProd, FRAC_SH, mode.rndEn);
    mulRes = mode.fracEn ? fRes : (mode.sel16 ? sRes : uRes);
    mulOvf = !mode.fracEn && (mode.sel16 ? sOvf : uOvf);
  end

  // in-place saturation path
  logic [W-1:0] sext48, satRes;
  logic fits48, satOvf;

  always_comb begin
    fits48 = sameBits(selVal, ACC_W - 1);
    sext48 = {{(W-ACC_W){selVal[ACC_W-1]}}, selVal[ACC_W-1:0]};
    if (mode.fracEn || mode.sel16) begin
      satOvf = !fits48;
      if (satOvf && mode.satEn) begin
        if (mode.fracEn) satRes = selVal[W-1] ? ~POS48 : POS48;
        else             satRes = selVal[W-1] ? ~POS32 : POS32;
      end else begin
        satRes = sext48;
      end
    end else begin
      satOvf = |selVal[W-1:ACC_W];
      if (satOvf && mode.satEn) satRes = (selVal > LIM53) ? '0 : MAX48U;
      else                      satRes = {{(W-ACC_W){1'b0}}, selVal[ACC_W-1:0]};
    end
  end

  // flag path
  logic zF, nF, evF;
  always_comb begin
    zF = (selVal == '0);
    nF = !zF && selVal[ACC_W-1];
    if (mode.fracEn)     evF = !sameBits(selVal, PROD_W);
    else if (mode.sel16) evF = !sameBits(selVal, OP_W);
    else                 evF = |selVal[W-1:OP_W];
  end

  // readout path
  logic [W-1:0] q16, q32;
  logic [OP_W-1:0] rdNext;
  always_comb begin
    q16 = shiftRound(selVal, FRAC_SH, 1'b1);
    q32 = shiftRound(selVal, HALF_SH, mode.rndEn);
    if (mode.fracEn && mode.sel16) begin
      if (mode.satEn && !sameBits(q16, HALF_W - 1)) rdNext = q16[W-1] ? NEG16R : POS16R;
      else rdNext = {{(OP_W-HALF_W){1'b0}}, q16[HALF_W-1:0]};
    end else if (mode.fracEn) begin
      if (mode.satEn && !sameBits(q32, OP_W - 1)) rdNext = q32[W-1] ? ~POS32[OP_W-1:0] : POS32[OP_W-1:0];
      else rdNext = q32[OP_W-1:0];
    end else if (mode.sel16) begin
      if (!sameBits(selVal, OP_W - 1)) rdNext = selVal[W-1] ? ~POS32[OP_W-1:0] : POS32[OP_W-1:0];
      else rdNext = selVal[OP_W-1:0];
    end else begin
      rdNext = (|selVal[W-1:OP_W]) ? '1 : selVal[OP_W-1:0];
    end
  end

  always_comb begin
    flagEvt    = '0;
    flagEvt.v  = (strb.mul && mulOvf) || (strb.sat && satOvf);
    flagEvt.z  = strb.flags && zF;
    flagEvt.n  = strb.flags && nF;
    flagEvt.ev = strb.flags && evF;
  end
  assign ovfEvt = strb.sat && satOvf && !strb.mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ACC; i++) accReg[i] <= '0;
      prodOut <= '0;
      rdData  <= '0;
    end else begin
      if (strb.load) accReg[accSel] <= loadData;
      if (strb.move) accReg[accSel] <= accReg[accSrc];
      if (strb.sat)  accReg[accSel] <= satRes;
      if (strb.mul)  prodOut <= mulRes;
      if (strb.read) rdData  <= rdNext;
    end
  end
endmodule

// File: rtl/macAccUnit.sv
module macAccUnit import macPkg::*; #(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [IDX_W-1:0]   accSel,
  input  logic [IDX_W-1:0]   accSrc,
  input  logic [OP_W-1:0]    opA,
  input  logic [OP_W-1:0]    opB,
  input  logic [WIDE_W-1:0]  loadData,
  input  logic [3:0]         modeIn,
  output logic [WIDE_W-1:0]  prodOut,
  output logic [OP_W-1:0]    rdData,
  output logic [WIDE_W-1:0]  accOut,
  output logic [3:0]         statusOut,
  output logic [NUM_ACC-1:0] pavOut,
  output logic [3:0]         modeOut
);
  strobe_t strb;
  mode_t   mode;
  status_t status, flagEvt;
  logic    ovfEvt;

  macCtrl #(.NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .accSel(accSel), .accSrc(accSrc), .modeIn(modeIn),
    .flagEvt(flagEvt), .ovfEvt(ovfEvt),
    .strb(strb), .mode(mode), .status(status), .pav(pavOut)
  );

  macDatapath #(.NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode),
    .accSel(accSel), .accSrc(accSrc), .opA(opA), .opB(opB), .loadData(loadData),
    .prodOut(prodOut), .rdData(rdData), .accOut(accOut),
    .flagEvt(flagEvt), .ovfEvt(ovfEvt)
  );

  assign statusOut = status;
  assign modeOut   = mode;
endmodule

// File: rtl/macAccChk.sv
module macAccChk import macPkg::*; #(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic [2:0]         cmdOp,
  input logic [IDX_W-1:0]   accSel,
  input logic [IDX_W-1:0]   accSrc,
  input logic [3:0]         modeIn,
  input logic [WIDE_W-1:0]  prodOut,
  input logic [OP_W-1:0]    rdData,
  input logic [3:0]         statusOut,
  input logic [NUM_ACC-1:0] pavOut,
  input logic [3:0]         modeOut
);
  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == CMD_MODE) |=> (statusOut == '0 && pavOut == '0 && modeOut == $past(modeIn)));

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdOp == CMD_MODE) |=> ((statusOut & $past(statusOut)) == $past(statusOut)));

  // R2
  umask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == CMD_MUL && modeOut[2:0] == 3'b000) |=> ((prodOut >> PROD_W) == '0));

  // R7
  half_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == CMD_READ && modeOut[2] && modeOut[1]) |=> ((rdData >> HALF_W) == '0));

  // R9
  move_pav_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == CMD_MOVE) |=> (pavOut[$past(accSel)] == $past(pavOut[accSrc])));
endmodule

bind macAccUnit macAccChk #(.NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_macAccChk (.*);

// File: tb/test_macAccUnit.sv
module test_macAccUnit;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [1:0] accSel = '0, accSrc = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [63:0] loadData = '0;
  logic [3:0] modeIn = '0;
  logic [63:0] prodOut, accOut;
  logic [31:0] rdData;
  logic [3:0] statusOut, pavOut, modeOut;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 0;

  logic [63:0] mAcc [4];
  logic [63:0] mProd;
  logic [31:0] mRd;
  logic [3:0] mStat, mPav, mMode;

  macAccUnit i_macAccUnit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .accSel(accSel), .accSrc(accSrc), .opA(opA), .opB(opB),
    .loadData(loadData), .modeIn(modeIn), .prodOut(prodOut), .rdData(rdData),
    .accOut(accOut), .statusOut(statusOut), .pavOut(pavOut), .modeOut(modeOut)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // mode bits: [3] rndEn, [2] fracEn, [1] sel16, [0] satEn
  function automatic logic [63:0] expMul(input logic [31:0] a, input logic [31:0] b,
                                         input logic [3:0] md, output logic ov);
    logic signed [63:0] sp;
    logic [63:0] up;
    logic [23:0] rem;
    sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    up = {32'b0, a} * {32'b0, b};
    ov = 1'b0;
    if (md[2]) begin
      rem = sp[23:0];
      sp = sp >>> 24;
      if (md[3] && (rem > 24'h800000 || (rem == 24'h800000 && sp[0]))) sp = sp + 1;
      return sp;
    end else if (md[1]) begin
      ov = (sp > 64'sd549755813887) || (sp < -64'sd549755813888);
      if (!ov) return sp;
      if (md[0]) return (sp < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
      return {{24{sp[39]}}, sp[39:0]};
    end else begin
      ov = up >= 64'h100_0000_0000;
      if (!ov) return up;
      if (md[0]) return 64'd1 << 50;
      return up & 64'hFF_FFFF_FFFF;
    end
  endfunction

  function automatic logic [63:0] expSat(input logic [63:0] v, input logic [3:0] md, output logic ov);
    logic signed [63:0] sv;
    sv = $signed(v);
    if (md[2] || md[1]) begin
      ov = (sv > 64'sd140737488355327) || (sv < -64'sd140737488355328);
      if (ov && md[0]) begin
        if (md[2]) return (sv < 0) ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF;
        return (sv < 0) ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
      end
      return {{16{v[47]}}, v[47:0]};
    end else begin
      ov = v >= 64'h1_0000_0000_0000;
      if (ov && md[0]) return (v > 64'h20_0000_0000_0000) ? 64'd0 : 64'hFFFF_FFFF_FFFF;
      return v & 64'hFFFF_FFFF_FFFF;
    end
  endfunction

  function automatic logic [3:0] expFlags(input logic [63:0] v, input logic [3:0] md, input logic pb);
    logic signed [63:0] sv;
    logic z, n, e;
    sv = $signed(v);
    z = (v == 64'd0);
    n = !z && v[47];
    if (md[2])      e = (sv > 64'sd1099511627775) || (sv < -64'sd1099511627776);
    else if (md[1]) e = (sv > 64'sd4294967295) || (sv < -64'sd4294967296);
    else            e = v >= 64'h1_0000_0000;
    return {e, pb, n, z};
  endfunction

  function automatic logic [31:0] expRead(input logic [63:0] v, input logic [3:0] md);
    logic signed [63:0] q;
    logic [63:0] rem;
    if (md[2] && md[1]) begin
      q = $signed(v) >>> 24;
      rem = {40'b0, v[23:0]};
      if (rem > 64'h800000 || (rem == 64'h800000 && q[0])) q = q + 1;
      if (md[0] && (q > 64'sd32767 || q < -64'sd32768)) return (q < 0) ? 32'h0000_8000 : 32'h0000_7FFF;
      return {16'b0, q[15:0]};
    end else if (md[2]) begin
      q = $signed(v) >>> 8;
      rem = {56'b0, v[7:0]};
      if (md[3] && (rem > 64'd128 || (rem == 64'd128 && q[0]))) q = q + 1;
      if (md[0] && (q > 64'sd2147483647 || q < -64'sd2147483648)) return (q < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return q[31:0];
    end else if (md[1]) begin
      q = $signed(v);
      if (q > 64'sd2147483647 || q < -64'sd2147483648) return (q < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return v[31:0];
    end else begin
      return (v >= 64'h1_0000_0000) ? 32'hFFFF_FFFF : v[31:0];
    end
  endfunction

  task automatic runCmd(input logic [2:0] op, input logic [1:0] sel, input logic [1:0] src,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] ld, input logic [3:0] md);
    logic ov;
    string tag;
    logic [3:0] eStat, ePav;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; accSel = sel; accSrc = src;
    opA = a; opB = b; loadData = ld; modeIn = md;
    eStat = mStat; ePav = mPav; tag = "R9";
    case (op)
      3'd1: begin
        tag = mMode[2] ? "R3" : (mMode[1] ? "R1" : "R2");
        mProd = expMul(a, b, mMode, ov);
        if (ov) eStat[2] = 1'b1;
      end
      3'd2: mAcc[sel] = ld;
      3'd3: begin mAcc[sel] = mAcc[src]; ePav[sel] = mPav[src]; end
      3'd4: begin
        tag = (mMode[2] || mMode[1]) ? "R4" : "R5";
        mAcc[sel] = expSat(mAcc[sel], mMode, ov);
        if (ov) begin eStat[2] = 1'b1; ePav[sel] = 1'b1; end
      end
      3'd5: begin tag = mMode[2] ? "R7" : "R8"; mRd = expRead(mAcc[sel], mMode); end
      3'd6: begin tag = "R6"; eStat = eStat | expFlags(mAcc[sel], mMode, mPav[sel]); end
      3'd7: begin tag = "R10"; mMode = md; eStat = '0; ePav = '0; end
      default: ;
    endcase
    mStat = eStat; mPav = ePav;
    @(negedge clk);
    cmdValid = 1'b0;
    if (op == 3'd1) chk(tag, "prodOut", prodOut, mProd);
    if (op == 3'd5) chk(tag, "rdData", {32'b0, rdData}, {32'b0, mRd});
    chk(tag, "accOut", accOut, mAcc[sel]);
    chk(tag, "statusOut", {60'b0, statusOut}, {60'b0, mStat});
    chk(tag, "pavOut", {60'b0, pavOut}, {60'b0, mPav});
    chk(tag, "modeOut", {60'b0, modeOut}, {60'b0, mMode});
  endtask

  function automatic logic [63:0] randLoad();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    case ($urandom_range(0, 4))
      0: return r;
      1: return {{16{r[47]}}, r[47:0]};
      2: return {{24{r[39]}}, r[39:0]};
      3: return {{32{r[31]}}, r[31:0]};
      default: return {{12{r[51]}}, r[51:0]};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 4; i++) mAcc[i] = '0;
    mProd = '0; mRd = '0; mStat = '0; mPav = '0; mMode = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 4; i++) begin
      accSel = 2'(i);
      #1 chk("R10", "reset accOut", accOut, 64'd0);
    end
    chk("R10", "reset prodOut", prodOut, 64'd0);
    chk("R10", "reset rdData", {32'b0, rdData}, 64'd0);
    chk("R10", "reset status", {56'b0, statusOut, pavOut}, 64'd0);

    // R1 signed product overflow, saturating and wrapping
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0011);
    runCmd(3'd1, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0);
    runCmd(3'd1, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);
    runCmd(3'd1, 0, 0, 32'hFFFF_FFFF, 32'h0000_1234, 0, 0);
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0010);
    runCmd(3'd1, 0, 0, 32'h4000_0000, 32'h0000_0400, 0, 0);
    // R2 unsigned product
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0000);
    runCmd(3'd1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0100, 0, 0);
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0001);
    runCmd(3'd1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0100, 0, 0);
    // R3 fractional halfway rounding to even
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b1100);
    runCmd(3'd1, 0, 0, 32'h0080_0000, 32'd1, 0, 0);
    runCmd(3'd1, 0, 0, 32'h0080_0000, 32'd3, 0, 0);
    runCmd(3'd1, 0, 0, 32'h0080_0000, 32'd5, 0, 0);
    runCmd(3'd1, 0, 0, 32'h0080_0001, 32'd5, 0, 0);
    // R5 unsigned saturation bounds
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0001);
    runCmd(3'd2, 1, 0, 0, 0, 64'h20_0000_0000_0001, 0);
    runCmd(3'd4, 1, 0, 0, 0, 0, 0);
    runCmd(3'd2, 2, 0, 0, 0, 64'h20_0000_0000_0000, 0);
    runCmd(3'd4, 2, 0, 0, 0, 0, 0);
    // R9 move carries sticky bit
    runCmd(3'd3, 3, 2, 0, 0, 0, 0);
    runCmd(3'd3, 2, 0, 0, 0, 0, 0);
    // R6 flags
    runCmd(3'd6, 3, 0, 0, 0, 0, 0);
    runCmd(3'd6, 0, 0, 0, 0, 0, 0);
    // R4 signed saturation clamp
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0011);
    runCmd(3'd2, 0, 0, 0, 0, 64'hFFF0_0000_0000_0000, 0);
    runCmd(3'd4, 0, 0, 0, 0, 0, 0);
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0101);
    runCmd(3'd2, 0, 0, 0, 0, 64'h0001_0000_0000_0000, 0);
    runCmd(3'd4, 0, 0, 0, 0, 0, 0);
    // R7 readout, 16-bit and 32-bit
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0111);
    runCmd(3'd2, 1, 0, 0, 0, 64'h0000_0001_2380_0000, 0);
    runCmd(3'd5, 1, 0, 0, 0, 0, 0);
    runCmd(3'd2, 1, 0, 0, 0, 64'h0000_7FFF_FF80_0000, 0);
    runCmd(3'd5, 1, 0, 0, 0, 0, 0);
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b1101);
    runCmd(3'd2, 1, 0, 0, 0, 64'h0000_0000_0000_0380, 0);
    runCmd(3'd5, 1, 0, 0, 0, 0, 0);
    runCmd(3'd2, 1, 0, 0, 0, 64'hFFFF_0000_0000_0000, 0);
    runCmd(3'd5, 1, 0, 0, 0, 0, 0);
    // R8 integer readout
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0010);
    runCmd(3'd5, 1, 0, 0, 0, 0, 0);
    runCmd(3'd7, 0, 0, 0, 0, 0, 4'b0000);
    runCmd(3'd5, 1, 0, 0, 0, 0, 0);

    // constrained random mix
    for (int k = 0; k < 700; k++) begin
      int r;
      logic [2:0] op;
      logic [31:0] a, b;
      r = $urandom_range(0, 99);
      if (r < 20)      op = 3'd1;
      else if (r < 36) op = 3'd2;
      else if (r < 44) op = 3'd3;
      else if (r < 60) op = 3'd4;
      else if (r < 78) op = 3'd5;
      else if (r < 92) op = 3'd6;
      else             op = 3'd7;
      a = $urandom();
      b = $urandom();
      if ($urandom_range(0, 2) == 0) b = b >> $urandom_range(8, 30);
      runCmd(op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), a, b,
             randLoad(), 4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule